// File: doc/BRIEF.md
# Grouped External Interrupt Arbiter

This block gathers a large number of external pin interrupts, organised as equal-sized groups, and reduces them to a handful of shared request lines for a main interrupt controller. Each pin has its own trigger mode. Both level and edge conditions are supported, and edges are judged against the pin value seen in the previous cycle. A detected condition on a pin whose mask bit is clear is latched into that pin's pending bit. Software clears a pending bit by writing 1 to it.

Groups that hold pending bits compete in an arbiter. The winning group keeps the grant until every pending bit in that group is clear, and only then does the arbiter choose again. Each group has a rotation enable. When a group with rotation enabled is granted, the search start moves to the group just after it, so that group becomes the lowest priority. When a group without rotation is granted, the search start stays where it is. The granted group drives one of the shared lines. Several groups share each line, so the interrupt handler reads the pending vector to find the pin that fired.

A wake request is also produced, and its rule depends on the power mode. In idle mode any pending pin raises it. In the deeper modes only pins of group 0 can raise it.

Top module: `ext_irq_grouper`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1 (masked), no group is granted, all shared lines are low and the wake request is low.
- R2: The 3-bit trigger mode of pin p sits at trig_mode_i[3p+2:3p]. The codes are: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge, 4 = either edge, and 5 to 7 = never triggers. An edge compares the pin with its value in the previous cycle. A detected event shows on pending_o in the cycle after the one in which it was sampled.
- R3: An event on a pin whose mask bit is 1 does not set its pending bit. The mask is replaced as a whole by mask_wdata_i when mask_we_i is high, and mask_o shows the value.
- R4: A 1 in pend_clr_i clears that pending bit on the next edge. If an event occurs on the same pin in the same cycle, the set takes priority, so a level-triggered pin whose level is still active stays pending.
- R5: When no group is granted, or the granted group has no pending bit left, the arbiter grants the first group with a pending bit. It searches upward from the current search start and wraps past the last group. The grant appears one cycle after the pending bits it is based on.
- R6: While the granted group still has any pending bit, grant_grp_o does not change and grant_valid_o stays high.
- R7: Granting a group whose rot_en_i bit is 0 leaves the search start unchanged. The search start is group 0 after reset.
- R8: Granting group g while rot_en_i[g] is 1 moves the search start to group g+1, wrapping to 0 after the last group.
- R9: Group g drives shared line g*NUM_LINES/NUM_GROUPS using integer division. Exactly one line is high while a grant is valid, and none is high otherwise.
- R10: power_mode_i uses 0 = run, 1 = idle, 2 = stop and 3 = sleep. The wake request follows pending_o in the same cycle. In run mode it is low. In idle mode it is high if any pending bit is set. In stop or sleep mode it is high only if a pending bit of group 0 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_GROUPS*PINS_PER_GROUP | Synchronised external pin levels |
| trig_mode_i | input | 3*NUM_GROUPS*PINS_PER_GROUP | Per-pin trigger mode codes |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_GROUPS*PINS_PER_GROUP | New mask value |
| pend_clr_i | input | NUM_GROUPS*PINS_PER_GROUP | Write-1 pending clear |
| rot_en_i | input | NUM_GROUPS | Per-group rotating priority enable |
| power_mode_i | input | 2 | Current power mode |
| mask_o | output | NUM_GROUPS*PINS_PER_GROUP | Current mask |
| pending_o | output | NUM_GROUPS*PINS_PER_GROUP | Pending bits |
| irq_line_o | output | NUM_LINES | Shared interrupt lines |
| grant_valid_o | output | 1 | A group holds the grant |
| grant_grp_o | output | $clog2(NUM_GROUPS) | Granted group index |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach is a rotating search start that changes the outcome. The arbiter only re-arbitrates once the granted group is empty, so a different winner shows up only when the competing groups become pending while another group holds the grant, and they lie on opposite sides of it. Directed sequences pulse one group, wait for its grant, and then pulse a group below it and a group above it. They clear the holder first with rotation off and then with rotation on, and expect opposite winners. Random phases mix edge-only and level modes with sparse clears and random rotation enables. Each cycle is compared against a bench model that tracks the search start.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [2:0] {
      TRIG_LOW  = 3'd0,
      TRIG_HIGH = 3'd1,
      TRIG_FALL = 3'd2,
      TRIG_RISE = 3'd3,
      TRIG_BOTH = 3'd4
   } trig_mode_e;

   typedef enum logic [1:0] {
      PWR_RUN   = 2'd0,
      PWR_IDLE  = 2'd1,
      PWR_STOP  = 2'd2,
      PWR_SLEEP = 2'd3
   } pwr_mode_e;

   localparam int unsigned TRIG_W = 3;

   // shared line that a group is folded onto
   function automatic int unsigned line_of(input int unsigned grp,
                                           input int unsigned n_grp,
                                           input int unsigned n_line);
      return (grp * n_line) / n_grp;
   endfunction

endpackage

// File: rtl/ext_irq_trig.sv
module ext_irq_trig
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 80
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        pin_i,
   input  logic [TRIG_W*NUM_PINS-1:0] mode_i,
   output logic [NUM_PINS-1:0]        event_o
);

   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_i;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [TRIG_W-1:0] md;
      assign md = mode_i[TRIG_W*p +: TRIG_W];
      always_comb begin
         case (md)
            TRIG_LOW:  event_o[p] = ~pin_i[p];
            TRIG_HIGH: event_o[p] = pin_i[p];
            TRIG_FALL: event_o[p] = prev_q[p] & ~pin_i[p];
            TRIG_RISE: event_o[p] = ~prev_q[p] & pin_i[p];
            TRIG_BOTH: event_o[p] = prev_q[p] ^ pin_i[p];
            default:   event_o[p] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend #(
   parameter int unsigned NUM_PINS = 80
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] event_i,
   input  logic                mask_we_i,
   input  logic [NUM_PINS-1:0] mask_wdata_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] pending_o,
   output logic [NUM_PINS-1:0] mask_o
);

   logic [NUM_PINS-1:0] mask_q;
   logic [NUM_PINS-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         pend_q <= '0;
      end else begin
         // a fresh event outranks a clear in the same cycle
         pend_q <= (pend_q & ~clr_i) | (event_i & ~mask_q);
         if (mask_we_i) mask_q <= mask_wdata_i;
      end
   end

   assign pending_o = pend_q;
   assign mask_o    = mask_q;

endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb #(
   parameter int unsigned NUM_GROUPS = 10,
   localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_GROUPS-1:0] grp_req_i,
   input  logic [NUM_GROUPS-1:0] rot_en_i,
   output logic                  grant_valid_o,
   output logic [GW-1:0]         grant_grp_o
);

   localparam bit POW2 = (NUM_GROUPS == (1 << GW));

   logic [GW-1:0] base_q, grant_q, win, base_nxt;
   logic          gv_q, found, hold;

   assign hold = gv_q && grp_req_i[grant_q];

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int i = 0; i < int'(NUM_GROUPS); i++) begin
         int idx;
         idx = int'(base_q) + i;
         if (idx >= int'(NUM_GROUPS)) idx = idx - int'(NUM_GROUPS);
         if (!found && grp_req_i[idx]) begin
            found = 1'b1;
            win   = GW'(idx);
         end
      end
   end

   if (POW2) begin : g_wrap_free
      assign base_nxt = win + 1'b1;
   end else begin : g_wrap_cmp
      assign base_nxt = (win == GW'(NUM_GROUPS - 1)) ? '0 : win + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gv_q    <= 1'b0;
         grant_q <= '0;
         base_q  <= '0;
      end else if (!hold) begin
         gv_q <= found;
         if (found) begin
            grant_q <= win;
            if (rot_en_i[win]) base_q <= base_nxt;
         end
      end
   end

   assign grant_valid_o = gv_q;
   assign grant_grp_o   = grant_q;

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_GROUPS     = 10,
   parameter int unsigned PINS_PER_GROUP = 8,
   parameter int unsigned NUM_LINES      = 5,
   localparam int unsigned NP = NUM_GROUPS * PINS_PER_GROUP,
   localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NP-1:0]         pin_i,
   input  logic [TRIG_W*NP-1:0]  trig_mode_i,
   input  logic                  mask_we_i,
   input  logic [NP-1:0]         mask_wdata_i,
   input  logic [NP-1:0]         pend_clr_i,
   input  logic [NUM_GROUPS-1:0] rot_en_i,
   input  logic [1:0]            power_mode_i,
   output logic [NP-1:0]         mask_o,
   output logic [NP-1:0]         pending_o,
   output logic [NUM_LINES-1:0]  irq_line_o,
   output logic                  grant_valid_o,
   output logic [GW-1:0]         grant_grp_o,
   output logic                  wake_o
);

   if (NUM_GROUPS < 1 || PINS_PER_GROUP < 1) begin : g_bad_size
      $error("ext_irq_grouper: groups and pins per group must be nonzero");
   end
   if (NUM_LINES < 1 || NUM_LINES > NUM_GROUPS) begin : g_bad_lines
      $error("ext_irq_grouper: NUM_LINES must lie in 1..NUM_GROUPS");
   end

   logic [NP-1:0]         evt;
   logic [NUM_GROUPS-1:0] grp_req;

   ext_irq_trig #(.NUM_PINS(NP)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_i),
      .mode_i  (trig_mode_i),
      .event_o (evt)
   );

   ext_irq_pend #(.NUM_PINS(NP)) u_pend (
      .clk          (clk),
      .rst_n        (rst_n),
      .event_i      (evt),
      .mask_we_i    (mask_we_i),
      .mask_wdata_i (mask_wdata_i),
      .clr_i        (pend_clr_i),
      .pending_o    (pending_o),
      .mask_o       (mask_o)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_req[g] = |pending_o[g*PINS_PER_GROUP +: PINS_PER_GROUP];
   end

   ext_irq_arb #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .grp_req_i     (grp_req),
      .rot_en_i      (rot_en_i),
      .grant_valid_o (grant_valid_o),
      .grant_grp_o   (grant_grp_o)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int g = 0; g < int'(NUM_GROUPS); g++) begin
            if (line_of(g, NUM_GROUPS, NUM_LINES) == l && grant_grp_o == GW'(g))
               hit = 1'b1;
         end
      end
      assign irq_line_o[l] = grant_valid_o & hit;
   end

   always_comb begin
      case (pwr_mode_e'(power_mode_i))
         PWR_IDLE:            wake_o = |grp_req;
         PWR_STOP, PWR_SLEEP: wake_o = grp_req[0];
         default:             wake_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ext_irq_grouper_chk.sv
module ext_irq_grouper_chk #(
   parameter int unsigned NUM_GROUPS     = 10,
   parameter int unsigned PINS_PER_GROUP = 8,
   parameter int unsigned NUM_LINES      = 5,
   localparam int unsigned NP = NUM_GROUPS * PINS_PER_GROUP,
   localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           power_mode_i,
   input logic [NP-1:0]        mask_o,
   input logic [NP-1:0]        pending_o,
   input logic [NUM_LINES-1:0] irq_line_o,
   input logic                 grant_valid_o,
   input logic [GW-1:0]        grant_grp_o,
   input logic                 wake_o
);

   logic [NUM_GROUPS-1:0] gp;
   logic                  held_pend;

   always_comb begin
      held_pend = 1'b0;
      for (int g = 0; g < int'(NUM_GROUPS); g++) begin
         gp[g] = |pending_o[g*PINS_PER_GROUP +: PINS_PER_GROUP];
         if (grant_grp_o == GW'(g) && gp[g]) held_pend = 1'b1;
      end
   end

   // R9
   lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_line_o) && (grant_valid_o == (|irq_line_o)));

   // R3
   masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending_o & ~$past(pending_o) & $past(mask_o)) == '0));

   // R6
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && held_pend) |=> (grant_valid_o && $stable(grant_grp_o)));

   // R5
   idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid_o && (|gp)) |=> grant_valid_o);

   // R10
   deep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (power_mode_i[1] && wake_o) |-> gp[0]);

   // R10
   run_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (power_mode_i == 2'd0) |-> !wake_o);

endmodule

bind ext_irq_grouper ext_irq_grouper_chk #(
   .NUM_GROUPS     (NUM_GROUPS),
   .PINS_PER_GROUP (PINS_PER_GROUP),
   .NUM_LINES      (NUM_LINES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .power_mode_i  (power_mode_i),
   .mask_o        (mask_o),
   .pending_o     (pending_o),
   .irq_line_o    (irq_line_o),
   .grant_valid_o (grant_valid_o),
   .grant_grp_o   (grant_grp_o),
   .wake_o        (wake_o)
);

// File: tb/tb_ext_irq_grouper.sv
module tb_ext_irq_grouper;
   localparam int NG  = 10;
   localparam int PPG = 8;
   localparam int NL  = 5;
   localparam int NP  = NG * PPG;
   localparam int GW  = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic [NP-1:0]   pin, mask_wdata, clr;
   logic [3*NP-1:0] mode;
   logic            mask_we;
   logic [NG-1:0]   rot;
   logic [1:0]      pmode;
   logic [NP-1:0]   mask_o, pending_o;
   logic [NL-1:0]   irq_line_o;
   logic            grant_valid_o, wake_o;
   logic [GW-1:0]   grant_grp_o;

   ext_irq_grouper dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .trig_mode_i(mode),
      .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .pend_clr_i(clr),
      .rot_en_i(rot), .power_mode_i(pmode), .mask_o(mask_o),
      .pending_o(pending_o), .irq_line_o(irq_line_o),
      .grant_valid_o(grant_valid_o), .grant_grp_o(grant_grp_o), .wake_o(wake_o)
   );

   int checks = 0, fails = 0;
   logic [NP-1:0] m_pend, m_mask, m_prev;
   logic          m_gv;
   int            m_gg, m_base;

   task automatic chk(input string req, input string what,
                      input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic trig_hit(input logic [2:0] md, input logic cur, input logic prv);
      case (md)
         3'd0: return !cur;
         3'd1: return cur;
         3'd2: return prv && !cur;
         3'd3: return !prv && cur;
         3'd4: return prv != cur;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic grp_has(input logic [NP-1:0] v, input int g);
      return |v[g*PPG +: PPG];
   endfunction

   task automatic model_step();
      logic [NP-1:0] ev;
      for (int p = 0; p < NP; p++) ev[p] = trig_hit(mode[3*p +: 3], pin[p], m_prev[p]);
      if (!(m_gv && grp_has(m_pend, m_gg))) begin
         logic f;
         f = 1'b0;
         for (int i = 0; i < NG; i++) begin
            int g;
            g = (m_base + i) % NG;
            if (!f && grp_has(m_pend, g)) begin
               f = 1'b1;
               m_gg = g;
            end
         end
         m_gv = f;
         if (f && rot[m_gg]) m_base = (m_gg + 1) % NG;
      end
      m_pend = (m_pend & ~clr) | (ev & ~m_mask);
      if (mask_we) m_mask = mask_wdata;
      m_prev = pin;
   endtask

   task automatic check_all();
      logic [NP-1:0] el;
      logic          ew;
      el = '0;
      if (m_gv) el[m_gg*NL/NG] = 1'b1;
      case (pmode)
         2'd1:       ew = |m_pend;
         2'd2, 2'd3: ew = grp_has(m_pend, 0);
         default:    ew = 1'b0;
      endcase
      chk("R2/R3/R4", "pending", pending_o, m_pend);
      chk("R3", "mask", mask_o, m_mask);
      chk("R5/R6", "grant_valid", NP'(grant_valid_o), NP'(m_gv));
      if (m_gv) chk("R5/R7/R8", "grant_grp", NP'(grant_grp_o), NP'(m_gg));
      chk("R9", "lines", NP'(irq_line_o), el);
      chk("R10", "wake", NP'(wake_o), NP'(ew));
   endtask

   task automatic tick();
      model_step();
      @(negedge clk);
      mask_we = 1'b0;
      check_all();
   endtask

   task automatic set_all_modes(input logic [2:0] md);
      for (int p = 0; p < NP; p++) mode[3*p +: 3] = md;
   endtask

   task automatic clear_all();
      clr = '1; tick(); clr = '0; tick(); tick();
   endtask

   function automatic logic [NP-1:0] rnd_vec(input int pct);
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = ($urandom % 100) < pct;
      return v;
   endfunction

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; pin = '0; mask_wdata = '0; clr = '0; mask_we = 1'b0;
      rot = '0; pmode = 2'd0;
      set_all_modes(3'd3);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      m_pend = '0; m_mask = '1; m_prev = '0; m_gv = 1'b0; m_gg = 0; m_base = 0;
      // R1 explicit reset state
      chk("R1", "pending after reset", pending_o, '0);
      chk("R1", "mask after reset", mask_o, '1);
      chk("R1", "grant after reset", NP'(grant_valid_o), '0);
      chk("R1", "lines after reset", NP'(irq_line_o), '0);
      chk("R1", "wake after reset", NP'(wake_o), '0);

      // R3: masked pin ignored while everything is masked
      pin[3] = 1'b1; tick(); pin[3] = 1'b0; tick();
      chk("R3", "masked event pending", pending_o, '0);

      // R2: every mode code on the pins of group 1
      mask_wdata = '1; mask_wdata[PPG +: PPG] = '0; mask_we = 1'b1; tick();
      for (int k = 0; k < PPG; k++) mode[3*(PPG+k) +: 3] = 3'(k);
      for (int c = 0; c < 12; c++) begin
         pin[PPG +: PPG] = (c % 3 == 0) ? '1 : '0;
         tick();
         if (c % 4 == 3) begin clr = '1; tick(); clr = '0; end
      end
      pin = '0; clear_all();

      // R4: level-high pin stays pending through clears
      set_all_modes(3'd3);
      mode[2:0] = 3'd1;
      mask_wdata = '0; mask_we = 1'b1; tick();
      pin[0] = 1'b1; tick();
      clr[0] = 1'b1; tick(); tick();
      chk("R4", "level re-set after clear", NP'(pending_o[0]), NP'(1'b1));
      pin[0] = 1'b0; tick(); clr[0] = 1'b0; tick();
      chk("R4", "cleared once level gone", NP'(pending_o[0]), '0);
      mode[2:0] = 3'd3;
      clear_all();

      // R7: fixed priority, holder 5, then 2 and 7 compete
      rot = '0;
      pin[5*PPG] = 1'b1; tick(); pin[5*PPG] = 1'b0; tick();
      chk("R5", "first grant", NP'(grant_grp_o), NP'(5));
      pin[2*PPG] = 1'b1; pin[7*PPG] = 1'b1; tick(); pin = '0; tick();
      clr[5*PPG] = 1'b1; tick(); clr = '0; tick();
      chk("R7", "fixed winner", NP'(grant_grp_o), NP'(2));
      clear_all();

      // R8: rotating priority, same sequence picks the group above
      rot = '1;
      pin[5*PPG] = 1'b1; tick(); pin[5*PPG] = 1'b0; tick();
      pin[2*PPG] = 1'b1; pin[7*PPG] = 1'b1; tick(); pin = '0; tick();
      clr[5*PPG] = 1'b1; tick(); clr = '0; tick();
      chk("R8", "rotating winner", NP'(grant_grp_o), NP'(7));
      clear_all();

      // R10: deep modes wake only on group 0
      pmode = 2'd2;
      pin[3*PPG+1] = 1'b1; tick(); pin = '0; tick();
      chk("R10", "stop mode other group", NP'(wake_o), '0);
      pmode = 2'd1; tick();
      chk("R10", "idle mode any group", NP'(wake_o), NP'(1'b1));
      pmode = 2'd3; pin[2] = 1'b1; tick(); pin = '0; tick();
      chk("R10", "sleep mode group 0", NP'(wake_o), NP'(1'b1));
      clear_all();

      // random phases: edge-only sparse, mixed modes, heavy levels
      for (int ph = 0; ph < 3; ph++) begin
         for (int p = 0; p < NP; p++)
            mode[3*p +: 3] = (ph == 0) ? 3'(2 + $urandom % 3) : 3'($urandom % 8);
         for (int c = 0; c < 4000; c++) begin
            int tp;
            tp = (ph == 0) ? 3 : 20;
            pin = pin ^ rnd_vec(tp);
            clr = rnd_vec(ph == 2 ? 30 : 8);
            if ($urandom % 50 == 0) begin
               mask_wdata = rnd_vec(30); mask_we = 1'b1;
            end
            if ($urandom % 20 == 0) rot = NG'($urandom);
            pmode = 2'($urandom % 4);
            tick();
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule